// File: doc/BRIEF.md
# Memory-Operand Address and Access Sequencer

This block takes one memory-type instruction at a time, works out its effective address, and runs the memory transactions that the instruction needs over a port that carries one word per request. A start pulse hands it the instruction word, the program counter (already advanced past the instruction), a base register value and a store-data register value. All of these are captured on that cycle. The sequencer then raises a read or write strobe and holds it until the memory answers with a one-cycle ready pulse.

It handles four ways of forming an address: offset from the program counter, offset from a base register, a pointer fetched from memory, and a zero-extended trap vector. Indirect forms take two transactions: the pointer read, then the data access at the pointer's value. The address-only load never touches memory. It returns the computed address as if it were load data. When an operation finishes, a one-cycle done pulse appears. For loads, the loaded value, its destination register index and the register and condition-code write enables are presented on that same cycle.

Top module: `memop_seq`

## Requirements
- R1: For opcodes 0010 (load) and 0011 (store), the address is `pc_next` plus instr[8:0] sign-extended to 16 bits, with wrap-around modulo 2^16.
- R2: For opcodes 0110 (load) and 0111 (store), the address is `base_val` plus instr[5:0] sign-extended to 16 bits.
- R3: For opcodes 1010 (load) and 1011 (store), the block first reads a pointer at the R1-style address. It then performs exactly one more access, at the address equal to the pointer word.
- R4: Opcode 1110 makes no memory request. At done, `ld_value` equals the R1-style address, and `ld_we` and `cc_we` are high.
- R5: For the loads 0010, 0110 and 1010, done presents the data word of the final read on `ld_value`, instr[11:9] on `ld_dst`, and `ld_we` and `cc_we` high. `cc_we` is never high without `ld_we` and done.
- R6: For the stores 0011, 0111 and 1011, the final access is a write carrying the captured `src_val`. `ld_we` and `cc_we` stay low.
- R7: Opcode 1111 makes exactly one read, at {8'h00, instr[7:0]}. At done, `ld_value` holds the word read, and `ld_we` and `cc_we` stay low.
- R8: While a request waits for `mem_ready`, its strobe and `mem_addr` stay unchanged. Each request completes on the cycle `mem_ready` is high.
- R9: `mem_rd` and `mem_wr` are never high together.
- R10: `done` is a one-cycle pulse. Operands are taken only from the start cycle. A start pulse while an operation is in progress is ignored.
- R11: Any other opcode produces done with no memory request, and `ld_we` and `cc_we` stay low.
- R12: While reset is asserted and on the cycle after it, `done`, `mem_rd`, `mem_wr`, `ld_we` and `cc_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| instr | input | 16 | Instruction word, opcode in bits [15:12] |
| pc_next | input | 16 | Program counter already advanced past the instruction |
| base_val | input | 16 | Base register value for base+offset forms |
| src_val | input | 16 | Register value to be stored |
| mem_addr | output | 16 | Memory request address |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | One-cycle completion of the pending request |
| ld_value | output | 16 | Value for the destination register (valid at done) |
| ld_dst | output | 3 | Destination register index |
| ld_we | output | 1 | Register write enable, pulsed with done |
| cc_we | output | 1 | Condition-code load enable, pulsed with done |
| done | output | 1 | Operation complete |

## Verification
The bench targets offset signs and program-counter wrap. A design that sign-extends the wrong field width, or zero-extends, lands at a distant address. For the indirect forms, the second access must go to the pointer word. A design that reuses the first address, or writes at the pointer location, would show up in the bench's log of accesses. The bench also checks that the address-only load and unknown opcodes never strobe memory, and that stores leave both write enables low. Two further cases are covered: a start pulse arriving mid-operation, and operand inputs changing after start. A design that restarted on the extra pulse or read operands late would issue extra accesses or wrong addresses.

// File: rtl/memop_pkg.sv
package memop_pkg;

  localparam logic [3:0] OPC_LD_PC   = 4'b0010;
  localparam logic [3:0] OPC_LD_BASE = 4'b0110;
  localparam logic [3:0] OPC_LD_IND  = 4'b1010;
  localparam logic [3:0] OPC_ST_PC   = 4'b0011;
  localparam logic [3:0] OPC_ST_BASE = 4'b0111;
  localparam logic [3:0] OPC_ST_IND  = 4'b1011;
  localparam logic [3:0] OPC_ADDR    = 4'b1110;
  localparam logic [3:0] OPC_VECTOR  = 4'b1111;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_PTR_READ,
    S_ACCESS,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    AM_PCREL,
    AM_BASE,
    AM_VECTOR
  } amode_e;

  typedef struct packed {
    logic   valid;
    logic   is_load;
    logic   is_store;
    logic   indirect;
    logic   addr_only;
    amode_e amode;
  } memop_ctl_t;

endpackage

// File: rtl/memop_decode.sv
module memop_decode
  import memop_pkg::*;
(
  input  logic [3:0] opcode,
  output memop_ctl_t ctl
);

  always_comb begin
    ctl = '{valid: 1'b0, is_load: 1'b0, is_store: 1'b0, indirect: 1'b0,
            addr_only: 1'b0, amode: AM_PCREL};
    case (opcode)
      OPC_LD_PC: begin
        ctl.valid   = 1'b1;
        ctl.is_load = 1'b1;
      end
      OPC_LD_BASE: begin
        ctl.valid   = 1'b1;
        ctl.is_load = 1'b1;
        ctl.amode   = AM_BASE;
      end
      OPC_LD_IND: begin
        ctl.valid    = 1'b1;
        ctl.is_load  = 1'b1;
        ctl.indirect = 1'b1;
      end
      OPC_ST_PC: begin
        ctl.valid    = 1'b1;
        ctl.is_store = 1'b1;
      end
      OPC_ST_BASE: begin
        ctl.valid    = 1'b1;
        ctl.is_store = 1'b1;
        ctl.amode    = AM_BASE;
      end
      OPC_ST_IND: begin
        ctl.valid    = 1'b1;
        ctl.is_store = 1'b1;
        ctl.indirect = 1'b1;
      end
      OPC_ADDR: begin
        ctl.valid     = 1'b1;
        ctl.addr_only = 1'b1;
      end
      OPC_VECTOR: begin
        ctl.valid = 1'b1;
        ctl.amode = AM_VECTOR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/memop_addrgen.sv
module memop_addrgen
  import memop_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PC_OFF_W   = 9,
  parameter int BASE_OFF_W = 6,
  parameter int VEC_W      = 8,
  localparam int SRC_W     = (PC_OFF_W > VEC_W) ?
                             ((PC_OFF_W > BASE_OFF_W) ? PC_OFF_W : BASE_OFF_W) :
                             ((VEC_W > BASE_OFF_W) ? VEC_W : BASE_OFF_W)
)(
  input  logic [SRC_W-1:0]  off_field,
  input  logic [WORD_W-1:0] pc_val,
  input  logic [WORD_W-1:0] base_val,
  input  amode_e            amode,
  output logic [WORD_W-1:0] pcrel_ea,
  output logic [WORD_W-1:0] base_ea,
  output logic [WORD_W-1:0] vec_ea,
  output logic [WORD_W-1:0] ea
);

  function automatic logic [WORD_W-1:0] add_pc_offset(
    input logic [WORD_W-1:0] pc, input logic [PC_OFF_W-1:0] off);
    logic [WORD_W-1:0] ext;
    ext = {{(WORD_W-PC_OFF_W){off[PC_OFF_W-1]}}, off};
    return pc + ext;
  endfunction

  function automatic logic [WORD_W-1:0] add_base_offset(
    input logic [WORD_W-1:0] base, input logic [BASE_OFF_W-1:0] off);
    logic [WORD_W-1:0] ext;
    ext = {{(WORD_W-BASE_OFF_W){off[BASE_OFF_W-1]}}, off};
    return base + ext;
  endfunction

  function automatic logic [WORD_W-1:0] vector_address(
    input logic [VEC_W-1:0] vec);
    return {{(WORD_W-VEC_W){1'b0}}, vec};
  endfunction

  assign pcrel_ea = add_pc_offset(pc_val, off_field[PC_OFF_W-1:0]);
  assign base_ea  = add_base_offset(base_val, off_field[BASE_OFF_W-1:0]);
  assign vec_ea   = vector_address(off_field[VEC_W-1:0]);

  always_comb begin
    case (amode)
      AM_BASE:   ea = base_ea;
      AM_VECTOR: ea = vec_ea;
      default:   ea = pcrel_ea;
    endcase
  end

endmodule

// File: rtl/memop_fsm.sv
module memop_fsm
  import memop_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int REG_W   = 3,
  parameter int DST_LSB = 9,
  localparam int FIELD_W = DST_LSB + REG_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] field_in,
  input  logic [WORD_W-1:0]  pc_in,
  input  logic [WORD_W-1:0]  base_in,
  input  logic [WORD_W-1:0]  src_in,
  input  memop_ctl_t         ctl_in,
  input  logic [WORD_W-1:0]  ea_in,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               mem_ready,
  output logic [FIELD_W-1:0] field_q,
  output logic [WORD_W-1:0]  pc_q,
  output logic [WORD_W-1:0]  base_q,
  output amode_e             amode_q,
  output logic [WORD_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic [WORD_W-1:0]  ld_value,
  output logic [REG_W-1:0]   ld_dst,
  output logic               ld_we,
  output logic               cc_we,
  output logic               done,
  output logic               start_take,
  output logic               op_addr_only,
  output logic               op_indirect,
  output logic               op_store
);

  seq_state_e        state_q;
  memop_ctl_t        ctl_q;
  logic [WORD_W-1:0] src_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              req_fire;

  assign start_take = (state_q == S_IDLE) && start;
  assign req_fire   = (mem_rd || mem_wr) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctl_q   <= '{valid: 1'b0, is_load: 1'b0, is_store: 1'b0, indirect: 1'b0,
                   addr_only: 1'b0, amode: AM_PCREL};
      field_q <= '0;
      pc_q    <= '0;
      base_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            ctl_q   <= ctl_in;
            field_q <= field_in;
            pc_q    <= pc_in;
            base_q  <= base_in;
            src_q   <= src_in;
            state_q <= S_ADDR;
          end
        end
        S_ADDR: begin
          addr_q <= ea_in;
          if (!ctl_q.valid) begin
            state_q <= S_DONE;
          end else if (ctl_q.addr_only) begin
            data_q  <= ea_in;
            state_q <= S_DONE;
          end else if (ctl_q.indirect) begin
            state_q <= S_PTR_READ;
          end else begin
            state_q <= S_ACCESS;
          end
        end
        S_PTR_READ: begin
          if (req_fire) begin
            addr_q  <= mem_rdata;
            state_q <= S_ACCESS;
          end
        end
        S_ACCESS: begin
          if (req_fire) begin
            if (!ctl_q.is_store) data_q <= mem_rdata;
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign amode_q      = ctl_q.amode;
  assign op_addr_only = ctl_q.addr_only;
  assign op_indirect  = ctl_q.indirect;
  assign op_store     = ctl_q.is_store;

  assign mem_addr  = addr_q;
  assign mem_wdata = src_q;
  assign mem_rd    = (state_q == S_PTR_READ) ||
                     ((state_q == S_ACCESS) && !ctl_q.is_store);
  assign mem_wr    = (state_q == S_ACCESS) && ctl_q.is_store;

  assign done     = (state_q == S_DONE);
  assign ld_we    = done && (ctl_q.is_load || ctl_q.addr_only);
  assign cc_we    = ld_we;
  assign ld_value = data_q;
  assign ld_dst   = field_q[DST_LSB +: REG_W];

endmodule

// File: rtl/memop_seq.sv
module memop_seq
  import memop_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int OPC_W      = 4,
  parameter int REG_W      = 3,
  parameter int DST_LSB    = 9,
  parameter int PC_OFF_W   = 9,
  parameter int BASE_OFF_W = 6,
  parameter int VEC_W      = 8,
  localparam int FIELD_W   = DST_LSB + REG_W,
  localparam int SRC_W     = (PC_OFF_W > VEC_W) ?
                             ((PC_OFF_W > BASE_OFF_W) ? PC_OFF_W : BASE_OFF_W) :
                             ((VEC_W > BASE_OFF_W) ? VEC_W : BASE_OFF_W)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc_next,
  input  logic [WORD_W-1:0] base_val,
  input  logic [WORD_W-1:0] src_val,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] ld_value,
  output logic [REG_W-1:0]  ld_dst,
  output logic              ld_we,
  output logic              cc_we,
  output logic              done
);

  memop_ctl_t         ctl_w;
  logic [FIELD_W-1:0] field_q_w;
  logic [WORD_W-1:0]  pc_q_w;
  logic [WORD_W-1:0]  base_q_w;
  amode_e             amode_w;
  logic [WORD_W-1:0]  pcrel_ea_w;
  logic [WORD_W-1:0]  base_ea_w;
  logic [WORD_W-1:0]  vec_ea_w;
  logic [WORD_W-1:0]  ea_w;
  logic               start_take_w;
  logic               op_addr_only_w;
  logic               op_indirect_w;
  logic               op_store_w;

  memop_decode u_decode (
    .opcode (instr[WORD_W-1 -: OPC_W]),
    .ctl    (ctl_w)
  );

  memop_addrgen #(
    .WORD_W     (WORD_W),
    .PC_OFF_W   (PC_OFF_W),
    .BASE_OFF_W (BASE_OFF_W),
    .VEC_W      (VEC_W)
  ) u_addrgen (
    .off_field (field_q_w[SRC_W-1:0]),
    .pc_val    (pc_q_w),
    .base_val  (base_q_w),
    .amode     (amode_w),
    .pcrel_ea  (pcrel_ea_w),
    .base_ea   (base_ea_w),
    .vec_ea    (vec_ea_w),
    .ea        (ea_w)
  );

  memop_fsm #(
    .WORD_W  (WORD_W),
    .REG_W   (REG_W),
    .DST_LSB (DST_LSB)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .field_in     (instr[FIELD_W-1:0]),
    .pc_in        (pc_next),
    .base_in      (base_val),
    .src_in       (src_val),
    .ctl_in       (ctl_w),
    .ea_in        (ea_w),
    .mem_rdata    (mem_rdata),
    .mem_ready    (mem_ready),
    .field_q      (field_q_w),
    .pc_q         (pc_q_w),
    .base_q       (base_q_w),
    .amode_q      (amode_w),
    .mem_addr     (mem_addr),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_wdata    (mem_wdata),
    .ld_value     (ld_value),
    .ld_dst       (ld_dst),
    .ld_we        (ld_we),
    .cc_we        (cc_we),
    .done         (done),
    .start_take   (start_take_w),
    .op_addr_only (op_addr_only_w),
    .op_indirect  (op_indirect_w),
    .op_store     (op_store_w)
  );

endmodule

// File: rtl/memop_seq_chk.sv
module memop_seq_chk #(
  parameter int WORD_W = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              start_take,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [WORD_W-1:0] mem_addr,
  input logic              done,
  input logic              ld_we,
  input logic              cc_we,
  input logic              op_addr_only,
  input logic              op_indirect,
  input logic              op_store
);

  logic [1:0] fire_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       fire_cnt <= '0;
    else if (start_take)                              fire_cnt <= '0;
    else if ((mem_rd || mem_wr) && mem_ready && fire_cnt != 2'd3)
                                                      fire_cnt <= fire_cnt + 2'd1;
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) && $stable(mem_addr));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cc_with_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |-> ld_we && done);

  assert_addr_only_nomem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_addr_only |-> (fire_cnt == 2'd0) && ld_we && cc_we);

  assert_indirect_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_indirect |-> fire_cnt == 2'd2);

  assert_store_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_store |-> !ld_we && !cc_we);

  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rst_n |=> !done && !mem_rd && !mem_wr && !ld_we && !cc_we);

endmodule

bind memop_seq memop_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_take   (start_take_w),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .done         (done),
  .ld_we        (ld_we),
  .cc_we        (cc_we),
  .op_addr_only (op_addr_only_w),
  .op_indirect  (op_indirect_w),
  .op_store     (op_store_w)
);

// File: tb/memop_seq_bench.sv
module memop_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_next = '0;
  logic [15:0] base_val = '0;
  logic [15:0] src_val = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [15:0] ld_value;
  logic [2:0]  ld_dst;
  logic        ld_we;
  logic        cc_we;
  logic        done;

  always #5 clk = ~clk;

  memop_seq u_memop_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
    .base_val(base_val), .src_val(src_val), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .ld_value(ld_value), .ld_dst(ld_dst), .ld_we(ld_we),
    .cc_we(cc_we), .done(done)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  // memory model: two override slots over a computed pattern
  logic        ov_en0 = 1'b0, ov_en1 = 1'b0;
  logic [15:0] ov_a0 = '0, ov_d0 = '0, ov_a1 = '0, ov_d1 = '0;

  // access log
  int          nacc = 0;
  logic [15:0] log_addr [4];
  logic        log_wr   [4];
  logic [15:0] log_data [4];

  int          waitc = 0;
  int          lat = 0;
  logic [15:0] req_addr0 = '0;

  function automatic logic [15:0] mdata(input logic [15:0] a);
    if (ov_en0 && a == ov_a0) return ov_d0;
    if (ov_en1 && a == ov_a1) return ov_d1;
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      waitc = 0;
    end else if (rst_n && (mem_rd || mem_wr)) begin
      if (waitc == 0) begin
        req_addr0 = mem_addr;
        lat = $urandom_range(0, 3);
      end
      if (waitc >= lat) begin
        chk(mem_addr == req_addr0, "R8", "address held while waiting", mem_addr, req_addr0);
        chk(!(mem_rd && mem_wr), "R9", "strobes exclusive", {14'd0, mem_rd, mem_wr}, 16'd0);
        mem_rdata = mdata(mem_addr);
        if (nacc < 4) begin
          log_addr[nacc] = mem_addr;
          log_wr[nacc]   = mem_wr;
          log_data[nacc] = mem_wdata;
        end
        nacc++;
        mem_ready = 1'b1;
      end else begin
        waitc++;
      end
    end
  end

  function automatic logic [15:0] sx9(input logic [15:0] w);
    return {{7{w[8]}}, w[8:0]};
  endfunction

  function automatic logic [15:0] sx6(input logic [15:0] w);
    return {{10{w[5]}}, w[5:0]};
  endfunction

  // run one operation and compare with an independently computed expectation
  task automatic run_op(input logic [15:0] ins, input logic [15:0] pc,
                        input logic [15:0] bv, input logic [15:0] sv,
                        input bit poke);
    logic [3:0]  opc;
    string       rq;
    int          en;
    logic [15:0] ea [2];
    bit          ew [2];
    bit          exp_we;
    bit          chk_val;
    logic [15:0] exp_val;
    logic [15:0] pcrel;
    bit          got;

    opc   = ins[15:12];
    pcrel = pc + sx9(ins);
    en = 0; exp_we = 0; chk_val = 0; exp_val = '0;
    ea[0] = '0; ea[1] = '0; ew[0] = 0; ew[1] = 0;
    case (opc)
      4'b0010: begin rq = "R1"; en = 1; ea[0] = pcrel; exp_we = 1; chk_val = 1; exp_val = mdata(pcrel); end
      4'b0011: begin rq = "R1"; en = 1; ea[0] = pcrel; ew[0] = 1; end
      4'b0110: begin rq = "R2"; en = 1; ea[0] = bv + sx6(ins); exp_we = 1; chk_val = 1; exp_val = mdata(ea[0]); end
      4'b0111: begin rq = "R2"; en = 1; ea[0] = bv + sx6(ins); ew[0] = 1; end
      4'b1010: begin rq = "R3"; en = 2; ea[0] = pcrel; ea[1] = mdata(pcrel); exp_we = 1; chk_val = 1; exp_val = mdata(ea[1]); end
      4'b1011: begin rq = "R3"; en = 2; ea[0] = pcrel; ea[1] = mdata(pcrel); ew[1] = 1; end
      4'b1110: begin rq = "R4"; en = 0; exp_we = 1; chk_val = 1; exp_val = pcrel; end
      4'b1111: begin rq = "R7"; en = 1; ea[0] = {8'h00, ins[7:0]}; chk_val = 1; exp_val = mdata(ea[0]); end
      default: begin rq = "R11"; en = 0; end
    endcase

    nacc = 0;
    @(negedge clk);
    instr = ins; pc_next = pc; base_val = bv; src_val = sv; start = 1'b1;
    @(negedge clk);
    // operands change after the start cycle; they must not matter (R10)
    instr = 16'($urandom); pc_next = 16'($urandom);
    base_val = 16'($urandom); src_val = 16'($urandom);
    start = poke;
    got = 0;
    for (int k = 0; k < 200; k++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
      start = 1'b0;
    end
    chk(got, "R10", "done reached", {15'd0, got}, 16'd1);
    if (got) begin
      chk(nacc == en, rq, "access count", 16'(nacc), 16'(en));
      for (int k = 0; k < 2; k++) begin
        if (k < en && k < nacc) begin
          chk(log_addr[k] == ea[k], rq, "access address", log_addr[k], ea[k]);
          chk(log_wr[k] == ew[k], rq, "access direction", {15'd0, log_wr[k]}, {15'd0, ew[k]});
          if (ew[k]) chk(log_data[k] == sv, "R6", "write data", log_data[k], sv);
        end
      end
      chk(ld_we == exp_we, exp_we ? "R5" : "R6", "ld_we", {15'd0, ld_we}, {15'd0, exp_we});
      chk(cc_we == exp_we, exp_we ? "R5" : "R6", "cc_we", {15'd0, cc_we}, {15'd0, exp_we});
      if (chk_val) chk(ld_value == exp_val, rq, "ld_value", ld_value, exp_val);
      if (exp_we) chk(ld_dst == ins[11:9], "R5", "ld_dst", {13'd0, ld_dst}, {13'd0, ins[11:9]});
      @(negedge clk);
      chk(!done, "R10", "done one cycle", {15'd0, done}, 16'd0);
      @(negedge clk);
      chk(!mem_rd && !mem_wr && nacc == en, "R10", "no restart after poke",
          16'(nacc), 16'(en));
    end
  endtask

  initial begin
    logic [3:0] opcs [9];
    void'($urandom(32'h1F2E3D4C));
    opcs[0] = 4'b0010; opcs[1] = 4'b0110; opcs[2] = 4'b1010; opcs[3] = 4'b0011;
    opcs[4] = 4'b0111; opcs[5] = 4'b1011; opcs[6] = 4'b1110; opcs[7] = 4'b1111;
    opcs[8] = 4'b0001;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr && !ld_we && !cc_we, "R12", "outputs quiet in reset",
        {11'd0, done, mem_rd, mem_wr, ld_we, cc_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_rd && !mem_wr && !ld_we && !cc_we, "R12", "outputs quiet after reset",
        {11'd0, done, mem_rd, mem_wr, ld_we, cc_we}, 16'd0);

    // R1: directed PC-relative load, negative offset
    ov_en0 = 1; ov_a0 = 16'h3FC8; ov_d0 = 16'h7153;
    run_op({4'b0010, 3'd2, 9'h1AF}, 16'h4019, 16'h0, 16'h0, 0);
    // R2: base+offset load
    run_op({4'b0110, 3'd1, 3'd2, 6'h1D}, 16'h0, 16'h2345, 16'h0, 0);
    // R3: indirect load and store through pointer
    ov_a0 = 16'h49E8; ov_d0 = 16'h2110; ov_en1 = 1; ov_a1 = 16'h2110; ov_d1 = 16'hB789;
    run_op({4'b1010, 3'd3, 9'h1CC}, 16'h4A1C, 16'h0, 16'h0, 0);
    run_op({4'b1011, 3'd3, 9'h1CC}, 16'h4A1C, 16'h0, 16'hBEEF, 0);
    ov_en0 = 0; ov_en1 = 0;
    // R4: address-only load
    run_op({4'b1110, 3'd5, 9'h1FD}, 16'h4019, 16'h0, 16'h0, 0);
    // R6: stores
    run_op({4'b0011, 3'd2, 9'h1AF}, 16'h4019, 16'h0, 16'h1234, 0);
    run_op({4'b0111, 3'd1, 3'd2, 6'h1D}, 16'h0, 16'h2345, 16'hFACE, 0);
    // R7: vector read
    run_op(16'hF025, 16'h3000, 16'h0, 16'h0, 0);
    // R11: unknown opcode
    run_op(16'h1234, 16'h3000, 16'h0, 16'h0, 0);
    // R1 boundaries: wrap at top of address space, largest positive offset
    run_op({4'b0010, 3'd7, 9'h0FF}, 16'hFFF0, 16'h0, 16'h0, 0);
    run_op({4'b0010, 3'd0, 9'h100}, 16'h0010, 16'h0, 16'h0, 0);
    // R2 boundary: most negative 6-bit offset
    run_op({4'b0110, 3'd4, 3'd0, 6'h20}, 16'h0, 16'h0005, 16'h0, 0);
    // R10: start pulse while busy
    run_op({4'b1010, 3'd6, 9'h010}, 16'h2000, 16'h0, 16'h0, 1);
    run_op({4'b1110, 3'd1, 9'h001}, 16'h2000, 16'h0, 16'h0, 1);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ri;
      ri = 16'($urandom);
      ri[15:12] = opcs[$urandom_range(0, 8)];
      run_op(ri, 16'($urandom), 16'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0));
    end

    summary();
    $finish;
  end

endmodule